// File: doc/BRIEF.md
# Flash Command and Status Interface

This block is the command front end of a parallel NOR flash device. The host writes command bytes on the data bus. Each recognised byte selects what later reads return: the memory array contents, the status register, or the identifier codes. An unrecognised byte leaves the read selection as it was. The block keeps an eight-bit status register. Its top bit reports whether the write state machine is ready. Its error bits stay set until software clears them with a dedicated command.

Reads are gated by an active-low chip enable and an active-low output enable, both sampled on the clock. The status value is captured into a read latch in the cycle the combined read enable first becomes true. It is not captured again until one of the strobes returns high. While an operation is running, a status read drives only bit 7, and an output-enable mask shows which data lines are driven. The abstract write-state-machine port takes single-cycle pulses for start, suspend, resume and done, plus a four-bit error code that is applied with done.

Top module: `flash_cui`

## Requirements
- R1: After reset the read mode is array, the status register is 0x80, and both `rd_data_o` and `rd_oe_o` are zero while no read is enabled.
- R2: Writing byte 0xFF selects array mode, 0x70 selects status mode and 0x90 selects identifier mode. The selected mode persists across any number of reads until another valid command is written.
- R3: A written byte other than 0xFF, 0x70, 0x90 or 0x50 leaves the read mode unchanged.
- R4: The status value is latched in the first clock cycle in which both `ce_ni` and `oe_ni` are low. It is not latched again until one of them goes high and then low again.
- R5: A status read whose latched bit 7 is 0 (busy) returns data 0x0000 with `rd_oe_o` = 0x0080. A status read whose latched bit 7 is 1 returns the status in the low byte, 0x00 in the high byte, and `rd_oe_o` = 0xFFFF.
- R6: A start pulse while ready and not suspended clears status bit 7. A done pulse while busy sets bit 7 and ORs `wsm_err_i[3]`, `[2]`, `[1]` and `[0]` into status bits 5, 4, 3 and 1 respectively. Bits 2 and 0 always read 0.
- R7: Error bits 5, 4, 3 and 1 remain set across later operations until a clear is accepted.
- R8: Byte 0x50 clears bits 5, 4, 3 and 1 only when bit 7 is 1 (idle or suspended). While busy it has no effect. It never changes the read mode.
- R9: A suspend pulse while busy sets status bits 7 and 6. A resume pulse while suspended clears both.
- R10: In identifier mode, word offset `addr_i[2:1]` = 0 returns 0x0089 and offset 1 returns 0x0014, or 0x0015 when `BIG_PART` is 1. `addr_i[0]` is ignored, the high byte is 0x00, and `rd_oe_o` is 0xFFFF.
- R11: In identifier mode, offset 2 returns on bit 0 the lock bit of block `addr_i[ADDR_W-1:BLK_LSB]`, and offset 3 returns `master_lock_i` on bit 0. All other bits read 0.
- R12: In array mode an enabled read returns `array_data_i` with `rd_oe_o` = 0xFFFF. Read outputs become valid in the cycle after both strobes are sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_wr_i | input | 1 | Command byte write strobe, one cycle |
| cmd_i | input | 8 | Command byte |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Read address (byte granular) |
| array_data_i | input | 16 | Array word for the current address |
| blk_lock_i | input | 2**(ADDR_W-BLK_LSB) | Per-block lock bits |
| master_lock_i | input | 1 | Master lock bit |
| wsm_start_i | input | 1 | Operation start pulse |
| wsm_suspend_i | input | 1 | Operation suspend pulse |
| wsm_resume_i | input | 1 | Operation resume pulse |
| wsm_done_i | input | 1 | Operation done pulse |
| wsm_err_i | input | 4 | Error code applied with done |
| rd_data_o | output | 16 | Read data |
| rd_oe_o | output | 16 | Per-line drive mask |

## Verification
The bench builds the block with `ADDR_W` = 8 and `BLK_LSB` = 4, which gives 16 blocks of 16 bytes. With that address space it can sweep every address in identifier mode under a non-uniform lock pattern, with the master lock both set and clear. It checks the manufacturer code, the device code, and each block's lock bit against values computed from the address arithmetic. The same small configuration keeps the status sequences short enough to walk error accumulation, clear-while-busy, suspend with clear, and held-strobe latching one step at a time.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_IDENT  = 2'd2
  } rd_mode_e;

  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR  = 8'h50;
  localparam logic [7:0] CMD_IDENT  = 8'h90;

  localparam logic [7:0] MFR_CODE   = 8'h89;
  localparam logic [7:0] DEV_SMALL  = 8'h14;
  localparam logic [7:0] DEV_BIG    = 8'h15;

  localparam int SR_READY = 7;
  localparam int SR_SUSP  = 6;
  localparam logic [15:0] BUSY_MASK = 16'h0080;
endpackage

// File: rtl/cui_cmd_decode.sv
module cui_cmd_decode
  import flash_cui_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_wr_i,
  input  logic [7:0] cmd_i,
  output rd_mode_e   mode_o,
  output logic       clr_req_o
);
  rd_mode_e mode_q;
  logic     known;

  assign known = (cmd_i == CMD_ARRAY) || (cmd_i == CMD_STATUS) ||
                 (cmd_i == CMD_IDENT) || (cmd_i == CMD_CLEAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_ARRAY;
    end else if (cmd_wr_i) begin
      unique case (cmd_i)
        CMD_ARRAY:  mode_q <= MODE_ARRAY;
        CMD_STATUS: mode_q <= MODE_STATUS;
        CMD_IDENT:  mode_q <= MODE_IDENT;
        default:    mode_q <= mode_q;
      endcase
    end
  end

  assign mode_o    = mode_q;
  assign clr_req_o = cmd_wr_i && (cmd_i == CMD_CLEAR);

  assert_unknown_keeps_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !known) |=> $stable(mode_q));

  assert_clear_keeps_mode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req_o |=> $stable(mode_q));
endmodule

// File: rtl/cui_status_reg.sv
module cui_status_reg
  import flash_cui_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       suspend_i,
  input  logic       resume_i,
  input  logic       done_i,
  input  logic [3:0] err_i,
  input  logic       clr_req_i,
  output logic [7:0] sr_o
);
  logic       ready_q;
  logic       susp_q;
  logic [3:0] err_q;
  logic       clr_ok;

  assign clr_ok = clr_req_i && ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b1;
      susp_q  <= 1'b0;
    end else if (start_i && ready_q && !susp_q) begin
      ready_q <= 1'b0;
    end else if (done_i && !ready_q) begin
      ready_q <= 1'b1;
    end else if (suspend_i && !ready_q) begin
      ready_q <= 1'b1;
      susp_q  <= 1'b1;
    end else if (resume_i && susp_q) begin
      ready_q <= 1'b0;
      susp_q  <= 1'b0;
    end
  end

  // done only lands while busy, clear only while ready: never both
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                err_q <= '0;
    else if (clr_ok)            err_q <= '0;
    else if (done_i && !ready_q) err_q <= err_q | err_i;
  end

  assign sr_o = {ready_q, susp_q, err_q[3], err_q[2], err_q[1], 1'b0, err_q[0], 1'b0};

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ok |=> ((err_q & $past(err_q)) == $past(err_q)));

  assert_clear_busy_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req_i && !ready_q && !done_i) |=> $stable(err_q));

  assert_done_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !ready_q) |=> sr_o[SR_READY]);

  assert_suspend_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_i && !ready_q && !done_i) |=> (sr_o[SR_READY] && sr_o[SR_SUSP]));
endmodule

// File: rtl/cui_read_mux.sv
module cui_read_mux
  import flash_cui_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BLK_LSB  = 4,
  parameter bit BIG_PART = 1'b0,
  localparam int BLK_W   = ADDR_W - BLK_LSB,
  localparam int NUM_BLK = 1 << BLK_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_ni,
  input  logic               oe_ni,
  input  rd_mode_e           mode_i,
  input  logic [7:0]         sr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [15:0]        array_data_i,
  input  logic [NUM_BLK-1:0] blk_lock_i,
  input  logic               master_lock_i,
  output logic [15:0]        data_o,
  output logic [15:0]        oe_o
);
  logic        rd_en;
  logic        en_q;
  logic [7:0]  latch_q;
  logic [7:0]  dev_code;
  logic [7:0]  id_byte;
  logic [BLK_W-1:0] blk_idx;
  logic        unused_addr_bits;

  assign rd_en   = !ce_ni && !oe_ni;
  assign blk_idx = addr_i[ADDR_W-1:BLK_LSB];
  assign unused_addr_bits = ^{addr_i[BLK_LSB-1:3], addr_i[0]};

  generate
    if (BIG_PART) begin : g_big
      assign dev_code = DEV_BIG;
    end else begin : g_small
      assign dev_code = DEV_SMALL;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      latch_q <= 8'h80;
    end else begin
      en_q <= rd_en;
      if (rd_en && !en_q) latch_q <= sr_i;
    end
  end

  always_comb begin
    unique case (addr_i[2:1])
      2'd0:    id_byte = MFR_CODE;
      2'd1:    id_byte = dev_code;
      2'd2:    id_byte = {7'd0, blk_lock_i[blk_idx]};
      default: id_byte = {7'd0, master_lock_i};
    endcase
  end

  always_comb begin
    data_o = '0;
    oe_o   = '0;
    if (en_q && rd_en) begin
      oe_o = 16'hFFFF;
      unique case (mode_i)
        MODE_STATUS: begin
          if (latch_q[SR_READY]) data_o = {8'h00, latch_q};
          else                   oe_o   = BUSY_MASK;
        end
        MODE_IDENT: data_o = {8'h00, id_byte};
        default:    data_o = array_data_i;
      endcase
    end
  end

  assert_latch_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && en_q) |=> $stable(latch_q));

  assert_busy_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o != '0 && mode_i == MODE_STATUS && !latch_q[SR_READY]) |-> (oe_o == BUSY_MASK));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (oe_o == '0 && data_o == '0));
endmodule

// File: rtl/flash_cui.sv
module flash_cui
  import flash_cui_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BLK_LSB  = 4,
  parameter bit BIG_PART = 1'b0,
  localparam int NUM_BLK = 1 << (ADDR_W - BLK_LSB)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_wr_i,
  input  logic [7:0]         cmd_i,
  input  logic               ce_ni,
  input  logic               oe_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [15:0]        array_data_i,
  input  logic [NUM_BLK-1:0] blk_lock_i,
  input  logic               master_lock_i,
  input  logic               wsm_start_i,
  input  logic               wsm_suspend_i,
  input  logic               wsm_resume_i,
  input  logic               wsm_done_i,
  input  logic [3:0]         wsm_err_i,
  output logic [15:0]        rd_data_o,
  output logic [15:0]        rd_oe_o
);
  rd_mode_e   mode;
  logic       clr_req;
  logic [7:0] sr;

  cui_cmd_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_wr_i  (cmd_wr_i),
    .cmd_i     (cmd_i),
    .mode_o    (mode),
    .clr_req_o (clr_req)
  );

  cui_status_reg u_sr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (wsm_start_i),
    .suspend_i (wsm_suspend_i),
    .resume_i  (wsm_resume_i),
    .done_i    (wsm_done_i),
    .err_i     (wsm_err_i),
    .clr_req_i (clr_req),
    .sr_o      (sr)
  );

  cui_read_mux #(
    .ADDR_W   (ADDR_W),
    .BLK_LSB  (BLK_LSB),
    .BIG_PART (BIG_PART)
  ) u_rd (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ce_ni         (ce_ni),
    .oe_ni         (oe_ni),
    .mode_i        (mode),
    .sr_i          (sr),
    .addr_i        (addr_i),
    .array_data_i  (array_data_i),
    .blk_lock_i    (blk_lock_i),
    .master_lock_i (master_lock_i),
    .data_o        (rd_data_o),
    .oe_o          (rd_oe_o)
  );
endmodule

// File: tb/flash_cui_tb.sv
module flash_cui_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 8;
  localparam int BLK_LSB = 4;
  localparam int NUM_BLK = 1 << (ADDR_W - BLK_LSB);

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               cmd_wr = 1'b0;
  logic [7:0]         cmd = '0;
  logic               ce_n = 1'b1;
  logic               oe_n = 1'b1;
  logic [ADDR_W-1:0]  addr = '0;
  logic [15:0]        arr = '0;
  logic [NUM_BLK-1:0] blk_lock = '0;
  logic               mlock = 1'b0;
  logic               st = 0, sus = 0, res = 0, dn = 0;
  logic [3:0]         err = '0;
  logic [15:0]        rd_data, rd_oe;

  int checks = 0;
  int errors = 0;
  logic [15:0] got_d, got_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cui #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .BIG_PART(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_wr_i(cmd_wr), .cmd_i(cmd),
    .ce_ni(ce_n), .oe_ni(oe_n), .addr_i(addr), .array_data_i(arr),
    .blk_lock_i(blk_lock), .master_lock_i(mlock),
    .wsm_start_i(st), .wsm_suspend_i(sus), .wsm_resume_i(res),
    .wsm_done_i(dn), .wsm_err_i(err),
    .rd_data_o(rd_data), .rd_oe_o(rd_oe)
  );

  task automatic check(input string req, input logic [15:0] d, input logic [15:0] m,
                       input logic [15:0] ed, input logic [15:0] em);
    checks++;
    if (d !== ed || m !== em) begin
      errors++;
      $display("FAIL %s data=%h mask=%h expected data=%h mask=%h", req, d, m, ed, em);
    end
  endtask

  task automatic write_cmd(input logic [7:0] c);
    @(negedge clk); cmd = c; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wsm(input int which, input logic [3:0] e);
    @(negedge clk);
    err = e;
    case (which)
      0: st = 1; 1: sus = 1; 2: res = 1; default: dn = 1;
    endcase
    @(negedge clk);
    st = 0; sus = 0; res = 0; dn = 0; err = '0;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); got_d = rd_data; got_m = rd_oe;
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: quiet outputs, R12 array passthrough at reset
    check("R1 idle", rd_data, rd_oe, 16'h0, 16'h0);
    arr = 16'hBEEF;
    do_read(8'h10);
    check("R12 array", got_d, got_m, 16'hBEEF, 16'hFFFF);
    write_cmd(8'h70);
    do_read(8'h00);
    check("R1 status reset", got_d, got_m, 16'h0080, 16'hFFFF);
    // R2 persistence
    do_read(8'h33);
    check("R2 persist", got_d, got_m, 16'h0080, 16'hFFFF);
    // R3 unknown byte
    write_cmd(8'h12);
    do_read(8'h00);
    check("R3 unknown", got_d, got_m, 16'h0080, 16'hFFFF);
    // R5 busy mask
    wsm(0, 4'h0);
    do_read(8'h00);
    check("R5 busy", got_d, got_m, 16'h0000, 16'h0080);
    // R4 hold strobes low across done
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    check("R4 first", rd_data, rd_oe, 16'h0000, 16'h0080);
    dn = 1'b1; err = 4'b1010;
    @(negedge clk); dn = 1'b0; err = '0;
    @(negedge clk);
    check("R4 held", rd_data, rd_oe, 16'h0000, 16'h0080);
    oe_n = 1'b1;
    @(negedge clk); oe_n = 1'b0;
    @(negedge clk);
    check("R4 refresh R6", rd_data, rd_oe, 16'h00A8, 16'hFFFF);
    ce_n = 1'b1; oe_n = 1'b1;
    // R7 accumulate
    wsm(0, 4'h0); wsm(3, 4'b0101);
    do_read(8'h00);
    check("R7 sticky", got_d, got_m, 16'h00BA, 16'hFFFF);
    // R8 clear ignored while busy
    wsm(0, 4'h0);
    write_cmd(8'h50);
    wsm(3, 4'h0);
    do_read(8'h00);
    check("R8 busy clear ignored", got_d, got_m, 16'h00BA, 16'hFFFF);
    write_cmd(8'h50);
    do_read(8'h00);
    check("R8 clear idle", got_d, got_m, 16'h0080, 16'hFFFF);
    // R9 suspend and clear while suspended
    wsm(0, 4'h0); wsm(3, 4'b0001);
    wsm(0, 4'h0); wsm(1, 4'h0);
    do_read(8'h00);
    check("R9 suspended", got_d, got_m, 16'h00C2, 16'hFFFF);
    write_cmd(8'h50);
    do_read(8'h00);
    check("R9 R8 clear suspended", got_d, got_m, 16'h00C0, 16'hFFFF);
    wsm(2, 4'h0);
    do_read(8'h00);
    check("R9 resumed", got_d, got_m, 16'h0000, 16'h0080);
    wsm(3, 4'h0);
    do_read(8'h00);
    check("R6 done", got_d, got_m, 16'h0080, 16'hFFFF);
    // R10 R11 sweep
    blk_lock = 16'hA5C3;
    write_cmd(8'h90);
    for (int ml = 0; ml < 2; ml++) begin
      mlock = ml[0];
      for (int a = 0; a < (1 << ADDR_W); a++) begin
        logic [15:0] exp;
        do_read(a[ADDR_W-1:0]);
        case ((a >> 1) & 3)
          0: exp = 16'h0089;
          1: exp = 16'h0014;
          2: exp = {15'd0, blk_lock[a >> BLK_LSB]};
          default: exp = {15'd0, mlock};
        endcase
        check(((a >> 1) & 3) < 2 ? "R10 ident" : "R11 lock", got_d, got_m, exp, 16'hFFFF);
      end
    end
    // R2 back to array
    write_cmd(8'hFF);
    arr = 16'h1234;
    do_read(8'h02);
    check("R2 R12 array again", got_d, got_m, 16'h1234, 16'hFFFF);
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk);
    check("R12 oe high quiet", rd_data, rd_oe, 16'h0, 16'h0);
    ce_n = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule